// File: doc/BRIEF.md
# Transceiver System Mode Controller

This block is the operating-mode state machine of a bus transceiver that powers itself from the battery. It selects one of five modes (off, normal, standby, sleep, overtemperature) from an active-low sleep request, digital flags for I/O-supply undervoltage, battery power-fail and chip overtemperature, and single-cycle wake strobes from the bus wake detector and the local wake pin. Analog comparators are outside the block and arrive as flags.

The controller remembers which wake sources have fired since the host last ran the transceiver. Those flags stop the block from going to sleep, they hold the receive-data pin low so the host can see a wake, and they clear only when normal mode is entered. Two cycle counters set timing. One is the hold time the sleep request must last in standby before sleep is entered. The other is the length of I/O-supply undervoltage after which sleep is forced. The inhibit output, which switches external regulators, is driven in normal and standby and released in every other mode.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: Synchronous active-high reset gives mode 0 (off), inhibit low, all wake flags 0 and force-low request low. Mode codes: 0 off, 1 normal, 2 standby, 3 sleep, 4 overtemperature.
- R2: Battery power-fail moves the block to off on the next edge from any mode. In off with no power-fail, the next mode is standby and wake flag bit 2 (power-on) is set.
- R3: In standby, a high sleep request line with no I/O undervoltage gives normal on the next edge. Entry to normal clears all three wake flags, and this clear wins over a wake strobe in the same cycle.
- R4: In normal, overtemperature gives mode 4. Otherwise a low sleep request or an I/O undervoltage gives standby.
- R5: In overtemperature mode, the block returns to standby once the overtemperature flag drops.
- R6: Standby gives sleep after the sleep request has been low in standby for SLP_HOLD+1 consecutive cycles and no wake flag is set.
- R7: While any wake flag is set, the sleep-request hold never leads to sleep. The block stays in standby.
- R8: Sleep returns to standby on a bus or local wake strobe, or on a high sleep request line with no I/O undervoltage. A high request line during I/O undervoltage leaves the block in sleep.
- R9: I/O undervoltage lasting UV_DLY+1 consecutive cycles in standby forces sleep even when wake flags are set. A gap of one cycle restarts the count.
- R10: A bus wake strobe sets flag bit 1 and a local wake strobe sets flag bit 0, but only in standby or sleep. In normal, strobes leave the flags at 0.
- R11: The force-low request is high in standby or sleep whenever flag bit 1 or bit 0 is set, and low otherwise.
- R12: Inhibit is high in normal and standby and low in sleep, off and overtemperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n | input | 1 | Sleep request, active low |
| vio_uv | input | 1 | I/O supply undervoltage flag |
| bat_uv | input | 1 | Battery below power-off threshold |
| over_temp | input | 1 | Chip overtemperature flag |
| bus_wake | input | 1 | Bus wake-up detected strobe |
| loc_wake | input | 1 | Local pin wake-up detected strobe |
| mode | output | 3 | Current mode code |
| inh_en | output | 1 | Inhibit output enable |
| wake_pend | output | 3 | Pending wakes: bit 2 power-on, bit 1 bus, bit 0 local |
| rxd_force_low | output | 1 | Request to hold receive-data pin low |

## Verification
Two functions can fall in the same cycle. A bus wake strobe can arrive on the very edge where standby becomes normal, so the wake-set path and the entry-clear path both act on one cycle. The bench brings the block out of sleep into standby and raises the strobe in the cycle that hands over to normal. Normal must appear with all flags at zero. A second overlap is forced sleep from undervoltage while wake flags are held. The bench checks that the flags survive into sleep and still hold the force-low request.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    typedef enum logic [2:0] {
        MD_OFF     = 3'd0,
        MD_NORMAL  = 3'd1,
        MD_STANDBY = 3'd2,
        MD_SLEEP   = 3'd3,
        MD_HOT     = 3'd4
    } mode_e;

    typedef struct packed {
        logic por;
        logic bus;
        logic loc;
    } wake_t;

    localparam wake_t WAKE_NONE = '{por: 1'b0, bus: 1'b0, loc: 1'b0};

    function automatic logic drives_inh(mode_e m);
        return (m == MD_NORMAL) || (m == MD_STANDBY);
    endfunction

    function automatic logic is_listening(mode_e m);
        return (m == MD_STANDBY) || (m == MD_SLEEP);
    endfunction

endpackage

// File: rtl/tsm_hold_timer.sv
module tsm_hold_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !cond)
            cnt <= '0;
        else if (cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign expired = cond && (cnt == LIM);

    // R6
    timer_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cond && cnt == LIM) |=> (!cond || cnt == LIM));

endmodule

// File: rtl/tsm_wake_reg.sv
module tsm_wake_reg
    import tsm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  mode_e         mode,
    input  logic          enter_normal,
    input  logic          bat_uv,
    input  logic          bus_wake,
    input  logic          loc_wake,
    output tsm_pkg::wake_t pend
);
    logic listen;
    assign listen = is_listening(mode);

    always_ff @(posedge clk) begin
        if (rst || enter_normal) begin
            pend <= WAKE_NONE;
        end else begin
            if (mode == MD_OFF && !bat_uv) pend.por <= 1'b1;
            if (listen && bus_wake)        pend.bus <= 1'b1;
            if (listen && loc_wake)        pend.loc <= 1'b1;
        end
    end

    // R10
    quiet_in_normal_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_NORMAL) |-> (pend == WAKE_NONE));

endmodule

// File: rtl/tsm_mode_fsm.sv
module tsm_mode_fsm
    import tsm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep_n,
    input  logic  vio_uv,
    input  logic  bat_uv,
    input  logic  over_temp,
    input  logic  wake_any,
    input  logic  pend_any,
    input  logic  hold_done,
    input  logic  uv_done,
    output mode_e mode,
    output logic  enter_normal
);
    mode_e nxt;

    always_comb begin
        nxt = mode;
        if (bat_uv) begin
            nxt = MD_OFF;
        end else begin
            unique case (mode)
                MD_OFF:     nxt = MD_STANDBY;
                MD_HOT:     if (!over_temp) nxt = MD_STANDBY;
                MD_NORMAL: begin
                    if (over_temp)              nxt = MD_HOT;
                    else if (!sleep_n || vio_uv) nxt = MD_STANDBY;
                end
                MD_STANDBY: begin
                    if (uv_done)                    nxt = MD_SLEEP;
                    else if (sleep_n && !vio_uv)    nxt = MD_NORMAL;
                    else if (hold_done && !pend_any) nxt = MD_SLEEP;
                end
                MD_SLEEP: begin
                    if (wake_any || (sleep_n && !vio_uv)) nxt = MD_STANDBY;
                end
                default:    nxt = MD_OFF;
            endcase
        end
    end

    assign enter_normal = (nxt == MD_NORMAL) && (mode != MD_NORMAL);

    always_ff @(posedge clk) begin
        if (rst) mode <= MD_OFF;
        else     mode <= nxt;
    end

    // R2
    power_fail_chk: assert property (@(posedge clk) disable iff (rst)
        bat_uv |=> (mode == MD_OFF));

    // R4
    hot_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_NORMAL && over_temp && !bat_uv) |=> (mode == MD_HOT));

    // R8
    sleep_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SLEEP && wake_any && !bat_uv) |=> (mode == MD_STANDBY));

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import tsm_pkg::*;
#(
    parameter int SLP_HOLD = 8,
    parameter int UV_DLY   = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_n,
    input  logic       vio_uv,
    input  logic       bat_uv,
    input  logic       over_temp,
    input  logic       bus_wake,
    input  logic       loc_wake,
    output logic [2:0] mode,
    output logic       inh_en,
    output logic [2:0] wake_pend,
    output logic       rxd_force_low
);
    mode_e cur;
    wake_t pend;
    logic  enter_normal, hold_done, uv_done, hold_cond;

    assign hold_cond = !sleep_n && (cur == MD_STANDBY);

    tsm_hold_timer #(.LIMIT(SLP_HOLD)) u_hold (
        .clk(clk), .rst(rst), .cond(hold_cond), .expired(hold_done));

    tsm_hold_timer #(.LIMIT(UV_DLY)) u_uv (
        .clk(clk), .rst(rst), .cond(vio_uv), .expired(uv_done));

    tsm_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .vio_uv(vio_uv),
        .bat_uv(bat_uv), .over_temp(over_temp),
        .wake_any(bus_wake || loc_wake), .pend_any(|pend),
        .hold_done(hold_done), .uv_done(uv_done),
        .mode(cur), .enter_normal(enter_normal));

    tsm_wake_reg u_wake (
        .clk(clk), .rst(rst), .mode(cur), .enter_normal(enter_normal),
        .bat_uv(bat_uv), .bus_wake(bus_wake), .loc_wake(loc_wake),
        .pend(pend));

    assign mode          = cur;
    assign wake_pend     = pend;
    assign inh_en        = drives_inh(cur);
    assign rxd_force_low = is_listening(cur) && (pend.bus || pend.loc);

    // R3
    normal_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == MD_NORMAL && $past(cur) != MD_NORMAL) |-> (pend == WAKE_NONE));

    // R7
    sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == MD_SLEEP && $past(cur) == MD_STANDBY && !$past(vio_uv))
            |-> ($past(pend) == WAKE_NONE));

    // R12
    inh_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == MD_SLEEP) |-> !inh_en);

endmodule

// File: tb/xcvr_mode_ctrl_test.sv
module xcvr_mode_ctrl_test;
    localparam int PERIOD = 10;
    localparam int SLP    = 8;
    localparam int UVD    = 12;

    logic clk = 1'b0;
    logic rst, sleep_n, vio_uv, bat_uv, over_temp, bus_wake, loc_wake;
    logic [2:0] mode, wake_pend;
    logic inh_en, rxd_force_low;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    xcvr_mode_ctrl #(.SLP_HOLD(SLP), .UV_DLY(UVD)) uut (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .vio_uv(vio_uv),
        .bat_uv(bat_uv), .over_temp(over_temp), .bus_wake(bus_wake),
        .loc_wake(loc_wake), .mode(mode), .inh_en(inh_en),
        .wake_pend(wake_pend), .rxd_force_low(rxd_force_low));

    // behavioural reference model
    int m_mode = 0;
    int m_pend = 0;
    int uv_seen = 0;
    int hold_seen = 0;

    always @(posedge clk) begin
        int nm, np;
        bit uv_long, hold_long, listen;
        if (rst) begin
            m_mode <= 0; m_pend <= 0; uv_seen <= 0; hold_seen <= 0;
        end else begin
            uv_long   = vio_uv && (uv_seen >= UVD);
            hold_long = !sleep_n && m_mode == 2 && (hold_seen >= SLP);
            listen    = (m_mode == 2 || m_mode == 3);
            nm = m_mode;
            if (bat_uv) nm = 0;
            else if (m_mode == 0) nm = 2;
            else if (m_mode == 4) nm = over_temp ? 4 : 2;
            else if (m_mode == 1) begin
                if (over_temp) nm = 4;
                else if (!sleep_n || vio_uv) nm = 2;
            end else if (m_mode == 2) begin
                if (uv_long) nm = 3;
                else if (sleep_n && !vio_uv) nm = 1;
                else if (hold_long && m_pend == 0) nm = 3;
            end else if (m_mode == 3) begin
                if (bus_wake || loc_wake || (sleep_n && !vio_uv)) nm = 2;
            end
            np = m_pend;
            if (nm == 1 && m_mode != 1) np = 0;
            else begin
                if (m_mode == 0 && !bat_uv) np = np | 4;
                if (listen && bus_wake) np = np | 2;
                if (listen && loc_wake) np = np | 1;
            end
            m_mode    <= nm;
            m_pend    <= np;
            uv_seen   <= vio_uv ? uv_seen + 1 : 0;
            hold_seen <= (!sleep_n && m_mode == 2) ? hold_seen + 1 : 0;
        end
    end

    always @(negedge clk) begin
        int e_inh, e_rxd;
        if (!rst && !finished) begin
            e_inh = (m_mode == 1 || m_mode == 2);
            e_rxd = (m_mode == 2 || m_mode == 3) && ((m_pend & 3) != 0);
            checks++;
            if (mode !== 3'(m_mode) || wake_pend !== 3'(m_pend) ||
                inh_en !== 1'(e_inh) || rxd_force_low !== 1'(e_rxd)) begin
                errors++;
                $display("FAIL model R1..R12: mode=%0d pend=%0d inh=%0d rxd=%0d expected mode=%0d pend=%0d inh=%0d rxd=%0d",
                    mode, wake_pend, inh_en, rxd_force_low, m_mode, m_pend, e_inh, e_rxd);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        rst = 1; sleep_n = 0; vio_uv = 0; bat_uv = 0; over_temp = 0;
        bus_wake = 0; loc_wake = 0;
        cyc(2);
        chk("R1 mode", mode, 0); chk("R1 inh", inh_en, 0);
        chk("R1 pend", wake_pend, 0); chk("R1 rxd", rxd_force_low, 0);
        rst = 0;
        cyc(1);
        chk("R2 off->standby", mode, 2); chk("R2 por flag", wake_pend, 4);
        chk("R12 inh standby", inh_en, 1);
        cyc(SLP + 10);
        chk("R7 pending blocks sleep", mode, 2);
        sleep_n = 1; cyc(1);
        chk("R3 normal", mode, 1); chk("R3 cleared", wake_pend, 0);
        bus_wake = 1; cyc(1); bus_wake = 0;
        chk("R10 ignored in normal", wake_pend, 0);
        over_temp = 1; cyc(1);
        chk("R4 overtemp", mode, 4); chk("R12 inh hot", inh_en, 0);
        cyc(3);
        chk("R5 held hot", mode, 4);
        over_temp = 0; cyc(1);
        chk("R5 back to standby", mode, 2);
        cyc(1);
        chk("R3 normal again", mode, 1);
        vio_uv = 1; cyc(1);
        chk("R4 uv to standby", mode, 2);
        vio_uv = 0; cyc(1);
        chk("R3 normal after uv", mode, 1);
        sleep_n = 0; cyc(SLP + 1);
        chk("R6 still standby", mode, 2);
        cyc(1);
        chk("R6 sleep", mode, 3); chk("R12 inh sleep", inh_en, 0);
        sleep_n = 1; vio_uv = 1; cyc(3);
        chk("R8 no exit under uv", mode, 3);
        sleep_n = 0; vio_uv = 0; cyc(2);
        loc_wake = 1; cyc(1); loc_wake = 0;
        chk("R8 local wake exit", mode, 2); chk("R10 local flag", wake_pend, 1);
        chk("R11 force low", rxd_force_low, 1);
        bus_wake = 1; cyc(1); bus_wake = 0;
        chk("R10 bus flag", wake_pend, 3);
        vio_uv = 1; cyc(UVD); vio_uv = 0; cyc(1); vio_uv = 1; cyc(UVD);
        chk("R9 restart", mode, 2);
        cyc(1);
        chk("R9 forced sleep", mode, 3); chk("R9 flags kept", wake_pend, 3);
        chk("R11 force low in sleep", rxd_force_low, 1);
        vio_uv = 0; sleep_n = 1; cyc(1);
        chk("R8 request exit", mode, 2);
        bus_wake = 1; cyc(1); bus_wake = 0;
        chk("R3 same-cycle normal", mode, 1); chk("R3 clear wins", wake_pend, 0);
        chk("R11 released", rxd_force_low, 0);
        bat_uv = 1; cyc(1);
        chk("R2 power fail", mode, 0); chk("R12 inh off", inh_en, 0);
        bat_uv = 0; cyc(1);
        chk("R2 recover", mode, 2); chk("R2 por again", wake_pend, 4);
        cyc(2);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog R1: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule